// File: doc/BRIEF.md
# Self-Timed EEPROM Program Sequencer

This block carries out the programming side of a small serial non-volatile memory whose cells are modelled as an on-chip register array. A command front end, which is not part of this block, hands it one decoded command at a time. Each command carries an operation code, an address, a data word, a word-size select and a program-enable level. The block keeps the erase/write enable latch. It also runs a self-timed busy period whose length depends on the operation kind. At the end of that period it commits the result to the array and emits a one-cycle done pulse, which the front end uses to drive its ready status.

The array holds 2^ADDR_W bytes, split across two byte lanes: even byte addresses in lane 0 and odd byte addresses in lane 1. In 8-bit mode the address selects a single byte. In 16-bit mode it selects a row, and the word is stored as {lane 1, lane 0}. A combinational read port serves the front end's read path. Reads never depend on the enable latch.

Top module: `eeprom_prog_seq`

## Requirements
- R1: After reset, busy_o and done_o are low and the erase/write enable latch is cleared, so programming commands start nothing.
- R2: A command is taken when sel_i and cmd_valid_i are high and busy_o is low. Operation codes are: 3'b000 disable, 3'b001 enable, 3'b010 erase word, 3'b011 write word, 3'b100 erase all, 3'b101 write all; other codes do nothing. Enable sets the latch and disable clears it, without a busy period. While the latch is clear, every programming command is ignored: no busy period and no array change.
- R3: A word erase sets every bit of the addressed word to 1 and leaves all other words unchanged.
- R4: A word write leaves exactly the supplied data in the addressed word, whatever the word held before, because the erase is automatic.
- R5: Erase-all sets every byte of the array to 8'hFF.
- R6: Write-all fills every word with the supplied data; no erase-all is needed beforehand.
- R7: busy_o rises in the cycle after acceptance and stays high for exactly T_WORD cycles (word erase or write), T_ERAL cycles (erase-all) or T_WRAL cycles (write-all). The array keeps its old contents while busy_o is high, and the new contents are readable in the first cycle with busy_o low.
- R8: When prog_en_i is low at acceptance, word write and write-all are ignored. Word erase and erase-all are not affected by prog_en_i.
- R9: Any command presented while busy_o is high, including in the last busy cycle, is ignored. A command presented in the done cycle is accepted.
- R10: A started cycle runs to completion even when sel_i drops. With sel_i low, cmd_valid_i is ignored.
- R11: done_o is high for exactly one cycle, the cycle right after the last busy cycle.
- R12: With wide_i high, addresses select a 16-bit word at row addr[ADDR_W-2:0], stored as {lane 1, lane 0}. With wide_i low, addresses select a byte: lane addr[0], row addr[ADDR_W-1:1]. In that mode only data[7:0] is stored and rd_data_o[15:8] reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Front end has the block selected |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Operation code (see R2) |
| cmd_addr_i | input | ADDR_W | Byte address (8-bit mode) or word address (16-bit mode) |
| cmd_data_i | input | 16 | Data for write and write-all |
| wide_i | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| prog_en_i | input | 1 | Program enable; low blocks writes |
| rd_addr_i | input | ADDR_W | Read address, interpreted by wide_i |
| rd_data_o | output | 16 | Read data |
| busy_o | output | 1 | Self-timed cycle in progress |
| done_o | output | 1 | One-cycle pulse when a cycle ends |

## Verification
The critical coincidence is a new command arriving in the same cycle that a busy period ends. The last busy cycle, where the commit happens, must still refuse the command. The done cycle, where busy is already low, must accept it. The bench provokes this in a small configuration by holding a competing write on the command port through the whole busy period and then presenting another in the done cycle. It judges the outcome three ways: whether busy restarts, the length of the new busy period, and a sweep of the whole array against a model in which only the first and last writes landed.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

  typedef enum logic [2:0] {
    OP_WDIS  = 3'b000,
    OP_WEN   = 3'b001,
    OP_ERASE = 3'b010,
    OP_WRITE = 3'b011,
    OP_ERAL  = 3'b100,
    OP_WRAL  = 3'b101,
    OP_NOP6  = 3'b110,
    OP_NOP7  = 3'b111
  } op_e;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int N_LANES = WORD_W / BYTE_W;

endpackage

// File: rtl/eeseq_wel.sv
module eeseq_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);

  logic en_q;
  logic en_d;

  always_comb begin
    en_d = en_q;
    if (clr_i)      en_d = 1'b0;
    else if (set_i) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  AST_WEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !en_o); // R2

endmodule

// File: rtl/eeseq_timer.sv
module eeseq_timer
  import eeseq_pkg::*;
#(
  parameter int CNT_W  = 21,
  parameter int T_WORD = 625000,
  parameter int T_ERAL = 750000,
  parameter int T_WRAL = 1875000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  op_e  kind_i,
  output logic busy_o,
  output logic last_o,
  output logic done_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             at_end;

  always_comb begin
    case (kind_i)
      OP_ERAL: load_val = CNT_W'(T_ERAL);
      OP_WRAL: load_val = CNT_W'(T_WRAL);
      default: load_val = CNT_W'(T_WORD);
    endcase
  end

  assign at_end = busy_q && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = at_end;
    if (start_i) begin
      cnt_d  = load_val;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (at_end) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign last_o = at_end;
  assign done_o = done_q;

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q); // R9
  AST_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (cnt_q != CNT_W'(1)) |=> busy_q); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R11
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && $past(busy_q)); // R11

endmodule

// File: rtl/eeseq_array.sv
module eeseq_array
  import eeseq_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              commit_i,
  input  op_e               op_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              rd_wide_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);

  localparam int ROW_W = ADDR_W - 1;
  localparam int ROWS  = 2 ** ROW_W;

  logic [ROW_W-1:0]  row_w, row_r;
  logic              all_op, erase_op;
  logic [BYTE_W-1:0] lane_rd [N_LANES];

  assign row_w    = wide_i    ? addr_i[ROW_W-1:0]    : addr_i[ADDR_W-1:1];
  assign row_r    = rd_wide_i ? rd_addr_i[ROW_W-1:0] : rd_addr_i[ADDR_W-1:1];
  assign all_op   = (op_i == OP_ERAL) || (op_i == OP_WRAL);
  assign erase_op = (op_i == OP_ERASE) || (op_i == OP_ERAL);

  for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
    logic [BYTE_W-1:0] mem [ROWS];
    logic [BYTE_W-1:0] wr_byte;
    logic              hit;

    always_comb begin
      if (erase_op)    wr_byte = {BYTE_W{1'b1}};
      else if (wide_i) wr_byte = data_i[BYTE_W*ln +: BYTE_W];
      else             wr_byte = data_i[BYTE_W-1:0];
      hit = wide_i || (addr_i[0] == 1'(ln));
    end

    always_ff @(posedge clk) begin
      if (commit_i) begin
        if (all_op) begin
          for (int r = 0; r < ROWS; r++) mem[r] <= wr_byte;
        end else if (hit) begin
          mem[row_w] <= wr_byte;
        end
      end
    end

    assign lane_rd[ln] = mem[row_r];
  end

  always_comb begin
    if (rd_wide_i) rd_data_o = {lane_rd[1], lane_rd[0]};
    else           rd_data_o = {{BYTE_W{1'b0}}, rd_addr_i[0] ? lane_rd[1] : lane_rd[0]};
  end

endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
  import eeseq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int T_WORD = 625000,
  parameter int T_ERAL = 750000,
  parameter int T_WRAL = 1875000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [15:0]       cmd_data_i,
  input  logic              wide_i,
  input  logic              prog_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_data_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int T_MAX0 = (T_WORD > T_ERAL) ? T_WORD : T_ERAL;
  localparam int T_MAX  = (T_MAX0 > T_WRAL) ? T_MAX0 : T_WRAL;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  op_e               op_in;
  logic              accept, is_prog, is_write, start;
  logic              wel_set, wel_clr, wel_en;
  logic              busy, last;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [15:0]       data_q, data_d;
  logic              wide_q, wide_d;

  assign op_in    = op_e'(cmd_op_i);
  assign accept   = sel_i && cmd_valid_i && !busy;
  assign is_prog  = (op_in == OP_ERASE) || (op_in == OP_WRITE) ||
                    (op_in == OP_ERAL)  || (op_in == OP_WRAL);
  assign is_write = (op_in == OP_WRITE) || (op_in == OP_WRAL);
  assign start    = accept && is_prog && wel_en && (!is_write || prog_en_i);
  assign wel_set  = accept && (op_in == OP_WEN);
  assign wel_clr  = accept && (op_in == OP_WDIS);

  always_comb begin
    op_d   = op_q;
    addr_d = addr_q;
    data_d = data_q;
    wide_d = wide_q;
    if (start) begin
      op_d   = op_in;
      addr_d = cmd_addr_i;
      data_d = cmd_data_i;
      wide_d = wide_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_WDIS;
      addr_q <= '0;
      data_q <= '0;
      wide_q <= 1'b0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      data_q <= data_d;
      wide_q <= wide_d;
    end
  end

  eeseq_wel u_wel (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wel_set),
    .clr_i (wel_clr),
    .en_o  (wel_en)
  );

  eeseq_timer #(
    .CNT_W  (CNT_W),
    .T_WORD (T_WORD),
    .T_ERAL (T_ERAL),
    .T_WRAL (T_WRAL)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .kind_i  (op_in),
    .busy_o  (busy),
    .last_o  (last),
    .done_o  (done_o)
  );

  eeseq_array #(
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk       (clk),
    .commit_i  (last),
    .op_i      (op_q),
    .wide_i    (wide_q),
    .addr_i    (addr_q),
    .data_i    (data_q),
    .rd_wide_i (wide_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign busy_o = busy;

  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel_en)); // R2
  AST_WRITE_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && ((op_q == OP_WRITE) || (op_q == OP_WRAL)) |-> $past(prog_en_i)); // R8

endmodule

// File: tb/eeprom_prog_seq_bench.sv
module eeprom_prog_seq_bench;

  localparam int AW = 5;
  localparam int NB = 2 ** AW;
  localparam int TW = 3;
  localparam int TE = 4;
  localparam int TA = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, cmd_valid, wide, prog_en;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [15:0]   cmd_data, rd_data;
  logic          busy, done;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;
  logic [7:0] m [NB];

  always #4 clk = ~clk;

  eeprom_prog_seq #(.ADDR_W(AW), .T_WORD(TW), .T_ERAL(TE), .T_WRAL(TA)) u_eeprom_prog_seq (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .wide_i(wide), .prog_en_i(prog_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mread(input int a, input bit w);
    if (w) return {m[2*(a % (NB/2))+1], m[2*(a % (NB/2))]};
    return {8'h00, m[a]};
  endfunction

  task automatic mupd(input logic [2:0] op, input int a, input logic [15:0] d, input bit w);
    case (op)
      3'b010: if (w) begin m[2*a] = 8'hFF; m[2*a+1] = 8'hFF; end else m[a] = 8'hFF;
      3'b011: if (w) begin m[2*a] = d[7:0]; m[2*a+1] = d[15:8]; end else m[a] = d[7:0];
      3'b100: for (int i = 0; i < NB; i++) m[i] = 8'hFF;
      3'b101: for (int i = 0; i < NB; i++) m[i] = (w && i[0]) ? d[15:8] : d[7:0];
      default: ;
    endcase
  endtask

  task automatic check_all(input string tag);
    int n = wide ? NB/2 : NB;
    for (int a = 0; a < n; a++) begin
      rd_addr = AW'(a);
      #1;
      chk(tag, int'(rd_data), mread(a, wide));
    end
  endtask

  task automatic issue(input logic [2:0] op, input int a, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(a); cmd_data = d;
    @(negedge clk);
    sel = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic run(input string tag, input logic [2:0] op, input int a,
                     input logic [15:0] d, input bit go, input int t_exp);
    int n;
    int old;
    rd_addr = AW'(a);
    #1;
    old = int'(rd_data);
    issue(op, a, d);
    if (go) begin
      chk({tag, " R7 array unchanged while busy"}, int'(rd_data), old);
      n = 0;
      while (busy && n < 100) begin n++; @(negedge clk); end
      chk({tag, " R7 busy length"}, n, t_exp);
      chk({tag, " R11 done in cycle after busy"}, int'(done), 1);
      mupd(op, a, d, wide);
      @(negedge clk);
      chk({tag, " R11 done single cycle"}, int'(done), 0);
    end else begin
      chk({tag, " no busy"}, int'(busy), 0);
      @(negedge clk);
      chk({tag, " no busy later"}, int'(busy), 0);
      chk({tag, " no done"}, int'(done), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; sel = 1'b0; cmd_valid = 1'b0; cmd_op = 3'b000; cmd_addr = '0;
    cmd_data = '0; wide = 1'b1; prog_en = 1'b1; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);

    run("R1 R2 write before enable", 3'b011, 1, 16'h1234, 0, 0);
    run("R1 R2 erase-all before enable", 3'b100, 0, 16'h0, 0, 0);

    issue(3'b001, 0, 16'h0);
    chk("R2 enable has no busy", int'(busy), 0);
    run("R5 erase-all", 3'b100, 0, 16'h0, 1, TE);
    check_all("R5 array all ones");

    issue(3'b000, 0, 16'h0);
    run("R2 write after disable", 3'b011, 2, 16'h0000, 0, 0);
    run("R2 erase after disable", 3'b010, 2, 16'h0000, 0, 0);
    check_all("R2 R12 array intact, read without latch");

    issue(3'b001, 0, 16'h0);
    for (int a = 0; a < NB/2; a++)
      run("R4 word write sweep", 3'b011, a, 16'(a * 16'h1357) ^ 16'hA5C3, 1, TW);
    check_all("R4 R12 16-bit readback");
    wide = 1'b0;
    check_all("R12 byte lane readback");

    for (int b = 0; b < NB; b++) begin
      if (b % 3 == 0) run("R3 byte erase", 3'b010, b, 16'h0, 1, TW);
      else if (b % 3 == 1) run("R4 R12 byte write", 3'b011, b, {8'hE7, 8'(b * 29 + 1)}, 1, TW);
    end
    check_all("R3 R4 R12 byte array");

    wide = 1'b1;
    run("R3 word erase", 3'b010, 5, 16'h0, 1, TW);
    check_all("R3 word erase leaves others");

    prog_en = 1'b0;
    run("R8 write blocked", 3'b011, 3, 16'h0000, 0, 0);
    run("R8 write-all blocked", 3'b101, 0, 16'h0000, 0, 0);
    run("R8 erase allowed", 3'b010, 4, 16'h0, 1, TW);
    check_all("R8 array after prog_en low");
    prog_en = 1'b1;

    run("R6 write-all 16-bit", 3'b101, 0, 16'hC35A, 1, TA);
    check_all("R6 16-bit fill");
    wide = 1'b0;
    check_all("R6 R12 16-bit fill as bytes");
    run("R6 write-all 8-bit", 3'b101, 0, 16'h996E, 1, TA);
    check_all("R6 8-bit fill");

    // R9 R10: competing commands across the busy window, sel dropped mid-cycle
    wide = 1'b1;
    issue(3'b011, 3, 16'h1234);
    chk("R9 first write busy", int'(busy), 1);
    sel = 1'b1; cmd_valid = 1'b1; cmd_op = 3'b011; cmd_addr = AW'(4); cmd_data = 16'hDEAD;
    @(negedge clk);
    chk("R9 still busy", int'(busy), 1);
    cmd_addr = AW'(5); cmd_data = 16'hBEEF;
    @(negedge clk);
    chk("R9 last busy cycle", int'(busy), 1);
    @(negedge clk);
    chk("R9 busy low in done cycle", int'(busy), 0);
    chk("R11 done after refused commands", int'(done), 1);
    mupd(3'b011, 3, 16'h1234, 1'b1);
    cmd_addr = AW'(6); cmd_data = 16'h0F0F;
    @(negedge clk);
    sel = 1'b0; cmd_valid = 1'b0;
    chk("R9 accepted in done cycle", int'(busy), 1);
    n = 1;
    @(negedge clk);
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R10 cycle completes with sel low", n, TW);
    chk("R10 done with sel low", int'(done), 1);
    mupd(3'b011, 6, 16'h0F0F, 1'b1);
    check_all("R9 only first and done-cycle writes landed");

    @(negedge clk);
    sel = 1'b0; cmd_valid = 1'b1; cmd_op = 3'b100;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 command ignored with sel low", int'(busy), 0);
    @(negedge clk);
    check_all("R10 array unchanged by deselected command");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule